// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell of a sum-of-products programmable logic device. It receives a set of product-term signals from the AND array, ORs them together, and turns the result into the level driven at one device pin. A two-bit setting picks whether the sum goes through a D flip-flop or straight to the pin, and whether the pin sees the true value or its complement. The pin is modelled as a data value plus a drive enable. The enable comes from a dedicated product term, so the pin can serve as an output, an input or a bidirectional line.

The cell also returns a feedback signal to the array. In registered operation this is the true flip-flop state, whatever the enable and polarity are. In combinational operation it is whatever level sits on the pin. That is the cell's own driven value when enabled, and the externally supplied level when not. The flip-flop has two array-wide controls. A preset term acts on the clock edge. A clear term acts at once without a clock and takes priority over preset. A synchronous active-high reset models power-up initialization and clears the flip-flop to low.

Top module: `cfg_macrocell`

## Requirements
- R1: The mode input `cfg` is decoded as follows: bit 1 = 0 selects registered operation and bit 1 = 1 selects combinational operation; bit 0 = 1 selects active-high and bit 0 = 0 selects active-low. So 00 is registered/active-low, 01 registered/active-high, 10 combinational/active-low and 11 combinational/active-high.
- R2: In combinational active-high mode, `pin_out` equals the OR of all bits of `pterm` in the same cycle, with no clock edge needed.
- R3: In either active-low mode, `pin_out` is the complement of the value that the matching active-high mode would drive.
- R4: In registered mode, each rising clock edge with preset, clear and reset all inactive loads the OR of `pterm` into the flip-flop. `pin_out` then shows that state, after polarity, from that edge on.
- R5: When `preset_term` is 1 at a rising clock edge, with clear and reset inactive, the flip-flop becomes 1 whatever the product terms are. Preset has no effect between edges.
- R6: While `clear_term` is 1 the flip-flop is 0. It falls to 0 as soon as `clear_term` rises, without waiting for a clock edge, and it stays 0 across edges where `preset_term` is also 1.
- R7: A rising clock edge with `rst` = 1 clears the flip-flop to 0. Afterwards a registered active-low cell drives `pin_out` = 1 and a registered active-high cell drives `pin_out` = 0.
- R8: `pin_oe` equals `oe_term` in every mode. When it is 0, `pin_out` is don't-care.
- R9: In registered mode, `fb` equals the flip-flop's true state, independent of `oe_term` and of the polarity bit.
- R10: In combinational mode, `fb` equals `pin_out` when `oe_term` is 1 and equals `pin_in` when `oe_term` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high power-up initialization; clears the flip-flop |
| cfg | input | 2 | Mode select: bit 1 bypasses the register, bit 0 selects active-high |
| pterm | input | NUM_PT | Product-term outputs from the array feeding this cell's OR |
| oe_term | input | 1 | Product term enabling the pin driver |
| preset_term | input | 1 | Shared preset term, acts on the clock edge |
| clear_term | input | 1 | Shared clear term, acts immediately |
| pin_in | input | 1 | Level present on the pin from outside when the driver is off |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback returned to the array |

## Verification
The clocked properties assume that `clear_term` changes only away from the rising edge and is not pulsed high and low again inside a single clock period where a preset or load is being checked. They also assume that `rst` is held high from time zero over the first edges. The stimulus sets every input at the falling edge and, for the immediate-clear case, raises `clear_term` in mid-period and holds it across the next rising edge, so each property sees a settled flip-flop. The configuration is changed only while no property window that depends on the previous mode is open.

// File: rtl/cell_pkg.sv
package cell_pkg;

    typedef enum logic [1:0] {
        MODE_REG_LO = 2'b00,
        MODE_REG_HI = 2'b01,
        MODE_CMB_LO = 2'b10,
        MODE_CMB_HI = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic bypass;
        logic act_high;
    } mode_dec_t;

    typedef struct packed {
        logic clear;
        logic init;
        logic preset;
    } reg_ctl_t;

    typedef struct packed {
        logic data;
        logic drive;
    } pin_drv_t;

    function automatic mode_dec_t decode_mode(input cell_mode_e m);
        mode_dec_t d;
        d.bypass   = (m == MODE_CMB_LO) || (m == MODE_CMB_HI);
        d.act_high = (m == MODE_REG_HI) || (m == MODE_CMB_HI);
        return d;
    endfunction

    function automatic logic apply_polarity(input logic v, input logic act_high);
        return act_high ? v : ~v;
    endfunction

endpackage

// File: rtl/cell_term_sum.sv
module cell_term_sum #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pterm,
    output logic              sum
);
    localparam int LAST = NUM_PT - 1;

    logic [NUM_PT-1:0] chain;

    assign chain[0] = pterm[0];

    generate
        for (genvar i = 1; i < NUM_PT; i++) begin : g_or
            assign chain[i] = chain[i-1] | pterm[i];
        end
    endgenerate

    assign sum = chain[LAST];

endmodule

// File: rtl/cell_state_reg.sv
module cell_state_reg
    import cell_pkg::*;
(
    input  logic     clk,
    input  reg_ctl_t ctl,
    input  logic     d,
    output logic     q
);
    always_ff @(posedge clk or posedge ctl.clear) begin
        if (ctl.clear) begin
            q <= 1'b0;
        end else if (ctl.init) begin
            q <= 1'b0;
        end else if (ctl.preset) begin
            q <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (ctl.init)
        ctl.clear |-> !q) else $error("clear term left register set"); // R6

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (ctl.init)
        (ctl.preset && !ctl.clear) |=> (q || ctl.clear)) else $error("preset ignored"); // R5

    AST_LOAD_SUM: assert property (@(posedge clk) disable iff (ctl.init)
        (!ctl.preset && !ctl.clear) |=> (ctl.clear || (q == $past(d)))) else $error("load mismatch"); // R4

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (ctl.init)
        $past(ctl.init) |-> !q) else $error("power-up clear missed"); // R7

endmodule

// File: rtl/cell_out_stage.sv
module cell_out_stage
    import cell_pkg::*;
(
    input  mode_dec_t mode,
    input  logic      sum,
    input  logic      q,
    input  logic      oe_term,
    output pin_drv_t  drv
);
    logic core;

    always_comb begin
        core      = mode.bypass ? sum : q;
        drv.data  = apply_polarity(core, mode.act_high);
        drv.drive = oe_term;
    end

endmodule

// File: rtl/cell_feedback_sel.sv
module cell_feedback_sel
    import cell_pkg::*;
(
    input  mode_dec_t mode,
    input  pin_drv_t  drv,
    input  logic      pin_in,
    input  logic      q,
    output logic      fb
);
    logic pin_level;

    always_comb begin
        pin_level = drv.drive ? drv.data : pin_in;
        fb        = mode.bypass ? pin_level : q;
    end

endmodule

// File: rtl/cfg_macrocell.sv
module cfg_macrocell
    import cell_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg,
    input  logic [NUM_PT-1:0] pterm,
    input  logic              oe_term,
    input  logic              preset_term,
    input  logic              clear_term,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb
);
    mode_dec_t mode;
    reg_ctl_t  ctl;
    pin_drv_t  drv;
    logic      sum;
    logic      q;

    assign mode       = decode_mode(cell_mode_e'(cfg));
    assign ctl.clear  = clear_term;
    assign ctl.init   = rst;
    assign ctl.preset = preset_term;

    cell_term_sum #(.NUM_PT(NUM_PT)) u_sum (
        .pterm (pterm),
        .sum   (sum)
    );

    cell_state_reg u_reg (
        .clk (clk),
        .ctl (ctl),
        .d   (sum),
        .q   (q)
    );

    cell_out_stage u_out (
        .mode    (mode),
        .sum     (sum),
        .q       (q),
        .oe_term (oe_term),
        .drv     (drv)
    );

    cell_feedback_sel u_fb (
        .mode   (mode),
        .drv    (drv),
        .pin_in (pin_in),
        .q      (q),
        .fb     (fb)
    );

    assign pin_out = drv.data;
    assign pin_oe  = drv.drive;

    AST_CMB_HIGH_SUM: assert property (@(posedge clk) disable iff (rst)
        (cfg == 2'b11) |-> (pin_out == (|pterm))) else $error("comb high mismatch"); // R2

    AST_REG_FB_STATE: assert property (@(posedge clk) disable iff (rst)
        (!cfg[1] && !cfg[0]) |-> (fb != pin_out)) else $error("reg feedback not true state"); // R9

    AST_CMB_FB_PIN: assert property (@(posedge clk) disable iff (rst)
        (cfg[1] && !oe_term) |-> (fb == pin_in)) else $error("comb feedback not pin"); // R10

    AST_OE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_term) |-> pin_oe) else $error("enable lost"); // R8

endmodule

// File: tb/tb_cfg_macrocell.sv
module tb_cfg_macrocell;
    localparam int NUM_PT = 8;
    localparam int NVEC   = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg = 2'b00;
    logic [NUM_PT-1:0] pterm = '0;
    logic              oe_term = 1'b0;
    logic              preset_term = 1'b0;
    logic              clear_term = 1'b0;
    logic              pin_in = 1'b0;
    logic              pin_out, pin_oe, fb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cfg_macrocell #(.NUM_PT(NUM_PT)) dut (
        .clk(clk), .rst(rst), .cfg(cfg), .pterm(pterm), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    // {cfg[1:0], pterm[7:0], oe, pin_in, exp_out, exp_fb}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b11, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'b11, 8'h04, 1'b1, 1'b0, 1'b1, 1'b1},
        {2'b10, 8'h04, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'b10, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
        {2'b11, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'b11, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'b10, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'b11, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1},
        {2'b10, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'b11, 8'h01, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clock_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cfg = 2'b00;
        oe_term = 1'b1;
        #1;
        // R7: reset state, registered active-low drives 1
        check(pin_out, 1'b1, "R7 reg-low after init");
        check(fb, 1'b0, "R7 feedback after init");
        cfg = 2'b01;
        #1;
        check(pin_out, 1'b0, "R7 reg-high after init");

        // R1 R2 R3 R8 R10: combinational vector walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            cfg     = VEC[i][13:12];
            pterm   = VEC[i][11:4];
            oe_term = VEC[i][3];
            pin_in  = VEC[i][2];
            #1;
            check(pin_oe, VEC[i][3], "R8 enable");
            if (VEC[i][3]) check(pin_out, VEC[i][1], "R1 R2 R3 comb out");
            check(fb, VEC[i][0], "R10 comb feedback");
        end

        // R4 R9: registered load, enable off
        @(negedge clk);
        cfg = 2'b01; pterm = 8'h10; oe_term = 1'b0; pin_in = 1'b0;
        clock_edge();
        check(fb, 1'b1, "R9 fb with oe off");
        check(pin_oe, 1'b0, "R8 oe off");
        @(negedge clk);
        oe_term = 1'b1;
        #1;
        check(pin_out, 1'b1, "R4 reg-high load");
        cfg = 2'b00;
        #1;
        check(pin_out, 1'b0, "R3 reg-low inverts");
        check(fb, 1'b1, "R9 fb same sense");
        pterm = 8'h00;
        clock_edge();
        check(fb, 1'b0, "R4 load zero");
        check(pin_out, 1'b1, "R4 R3 reg-low zero");

        // R5: preset on edge
        @(negedge clk);
        cfg = 2'b01; preset_term = 1'b1;
        #1;
        check(pin_out, 1'b0, "R5 no effect before edge");
        clock_edge();
        check(pin_out, 1'b1, "R5 preset sets");
        @(negedge clk);
        preset_term = 1'b0;
        clock_edge();
        check(pin_out, 1'b0, "R4 after preset");

        // R6: immediate clear, wins over preset
        @(negedge clk);
        preset_term = 1'b1;
        clock_edge();
        check(fb, 1'b1, "R5 preset before clear");
        #1;
        clear_term = 1'b1;
        #1;
        check(pin_out, 1'b0, "R6 clear without clock");
        check(fb, 1'b0, "R6 fb cleared");
        clock_edge();
        check(fb, 1'b0, "R6 clear beats preset");
        @(negedge clk);
        clear_term = 1'b0;
        clock_edge();
        check(fb, 1'b1, "R5 preset after clear");

        // R7: reset clears a set register
        @(negedge clk);
        preset_term = 1'b0; pterm = 8'h02; rst = 1'b1;
        clock_edge();
        check(fb, 1'b0, "R7 init clears");
        @(negedge clk);
        rst = 1'b0; cfg = 2'b00;
        #1;
        check(pin_out, 1'b1, "R7 reg-low after reinit");

        finish_run();
    end
endmodule